// File: doc/BRIEF.md
# Manchester Line Receiver with Preamble Lock

This block turns an oversampled Manchester line into a stream of decoded bits. The line reaches the block already synchronized to the local clock. The local clock runs at `OVS` samples per bit cell and has no fixed phase or rate relation to the sender. While it is not locked, the block hunts for an alternating acquisition pattern. It locks its bit-cell counter onto the falling mid-cell edge that completes that pattern.

Once locked, the block judges every edge against its own idea of where the cell centre should be. Edges close to the expected centre carry data and timing. Edges near a cell boundary are skipped. The counter is pulled one sample per cell toward each accepted centre edge, so a sender that runs slightly fast or slow is followed. One quarter of a bit after each centre the decoded bit is presented with a one-cycle strobe. When a cell passes without a usable centre edge, the block pulses an error, gives up lock and goes back to hunting.

Top module: `manchester_rx`

## Requirements
- R1: While `rst_n` is low and at the first sample after it rises, `locked`, `bit_valid` and `decode_error` are 0.
- R2: Lock is declared only when four mid-cell edges arrive in the order rising, falling, rising, falling, each one bit (OVS ± OVS/4 samples) after the one before. `locked` rises the cycle after the final falling edge is detected. The four acquisition bits are not presented, and the first presented bit is the cell after the locking edge.
- R3: Acquisition succeeds from any starting phase of the line. It also succeeds when the alternating stream begins with a 0, in which case lock falls on the first complete 1,0,1,0 group.
- R4: Each decoded bit is 1 for a rising (low-to-high) mid-cell edge and 0 for a falling one. Exactly one `bit_valid` pulse is produced per bit cell, a quarter bit after the cell centre. Consecutive strobes are OVS-1 to OVS+1 cycles apart.
- R5: An edge further than OVS/4 samples from the tracked centre is not used for decoding or timing. Boundary edges between equal bits (runs of 1s or 0s) therefore leave the output unaffected.
- R6: A sender whose rate is off by ±1 % is decoded without error over at least 88-bit frames.
- R7: Data edges displaced by up to 2 samples (one eighth of a bit at OVS=16) are decoded without error.
- R8: When no usable centre edge has been seen by the strobe point of a cell, `decode_error` pulses for one cycle, `locked` falls in that same cycle and hunting resumes. A following clean preamble locks again. A single centre edge displaced by more than a quarter bit therefore corrupts the frame.
- R9: `bit_valid` is asserted only while `locked` is 1 and never in the same cycle as `decode_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, OVS cycles per bit cell |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_in | input | 1 | Synchronized, oversampled line level |
| bit_out | output | 1 | Decoded bit, qualified by `bit_valid` |
| bit_valid | output | 1 | One-cycle strobe per decoded bit |
| locked | output | 1 | Bit-cell timing is locked |
| decode_error | output | 1 | One-cycle pulse when a cell lacks a centre edge |

## Verification
The bench builds the receiver with OVS=16. At that setting a quarter bit is exactly 4 samples, so a 2-sample jitter (which must decode) and a single 6-sample displacement (which must break the frame) fall on opposite sides of the acceptance limit. The 1 % rate offset at this oversampling makes the line drift about 0.16 sample per bit. Over a long frame this drift is enough to need several one-sample corrections, which exercises the tracking. Random start phases are drawn at hundredth-sample resolution, so the locking edge lands at every quantization offset.

// File: rtl/mrx_pkg.sv
// Shared types for the Manchester line receiver.
// Assumes nothing beyond a synthesizable enum.
package mrx_pkg;

    // Pending phase correction, applied once per cell at the half-cell point.
    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,   // counter runs freely
        ADJ_SLIP = 2'd1,   // hold the counter one sample (edge came late)
        ADJ_SKIP = 2'd2    // advance the counter one extra sample (edge came early)
    } adj_e;

endpackage

// File: rtl/mrx_edge_det.sv
// Line edge detector.
// Registers the synchronized line once and compares it with the prior sample
// to produce single-cycle rising and falling edge flags.
// Assumes rx is already synchronized to clk.
module mrx_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o,
    output logic fall_o
);

    logic cur_q;
    logic prv_q;

    // Two-deep sample history of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= 1'b0;
            prv_q <= 1'b0;
        end else begin
            cur_q <= line_i;
            prv_q <= cur_q;
        end
    end

    // Edge flags from the sample history.
    always_comb begin
        rise_o = cur_q & ~prv_q;
        fall_o = ~cur_q & prv_q;
    end

endmodule

// File: rtl/mrx_acq.sv
// Acquisition hunter.
// While enabled, measures the spacing between successive line edges and
// counts a chain of alternating-polarity edges spaced one bit apart.
// Flags a hit on the falling edge that completes rise/fall/rise/fall.
// Assumes the line idles without edges or with edges far apart between frames.
module mrx_acq #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic hit_o
);

    localparam int QTR = OVS / 4;
    localparam int LO  = OVS - QTR;
    localparam int HI  = OVS + QTR;
    localparam int SAT = HI + 1;
    localparam int GW  = $clog2(SAT + 1);

    logic [GW-1:0] gap_q;
    logic          lastpol_q;
    logic [1:0]    chain_q;
    logic          edge_any;
    logic          spacing_ok;
    logic          good;

    // Classify the current edge against the previous one.
    always_comb begin
        edge_any   = rise_i | fall_i;
        spacing_ok = (gap_q >= GW'(LO)) && (gap_q <= GW'(HI));
        good       = edge_any && spacing_ok && (rise_i != lastpol_q);
        hit_o      = en_i && fall_i && good && (chain_q >= 2'd2);
    end

    // Edge spacing counter and alternating-edge chain.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            gap_q     <= GW'(SAT);
            lastpol_q <= 1'b0;
            chain_q   <= 2'd0;
        end else if (edge_any) begin
            gap_q     <= GW'(1);
            lastpol_q <= rise_i;
            if (hit_o || !good) begin
                chain_q <= 2'd0;
            end else if (chain_q != 2'd3) begin
                chain_q <= chain_q + 2'd1;
            end
        end else if (gap_q != GW'(SAT)) begin
            gap_q <= gap_q + GW'(1);
        end
    end

endmodule

// File: rtl/mrx_track.sv
// Locked bit-cell tracker and decoder.
// Holds a phase counter whose zero is the expected cell centre. Accepts the
// first edge within a quarter bit of that centre, decodes its direction, and
// strobes the bit a quarter bit after the centre. Each accepted edge queues a
// one-sample correction applied at the half-cell point. A cell with no
// accepted edge by the strobe point raises an error and drops lock.
// Assumes OVS is a power of two and at least 8.
module mrx_track
    import mrx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic bit_o,
    output logic valid_o,
    output logic err_o,
    output logic locked_o
);

    localparam int HALF = OVS / 2;
    localparam int QTR  = OVS / 4;
    localparam int PW   = $clog2(OVS);

    logic [PW-1:0] ph_q;
    logic          lock_q;
    logic          seen_q;
    logic          pol_q;
    logic          mute_q;
    adj_e          adj_q;
    logic          bit_q;
    logic          val_q;
    logic          err_q;

    int            off_i;
    logic          in_win;
    logic          acc;
    logic          strobe;
    logic          hit;
    logic          dec_bit;
    logic [PW-1:0] ph_inc;

    // Signed offset of the current sample from the expected centre.
    always_comb begin
        off_i = int'(ph_q);
        if (off_i >= HALF) begin
            off_i = off_i - OVS;
        end
    end

    // Edge acceptance window, strobe point and decoded value.
    always_comb begin
        in_win  = (off_i >= -QTR) && (off_i <= QTR);
        acc     = lock_q && (rise_i | fall_i) && in_win && !seen_q;
        strobe  = lock_q && (ph_q == PW'(QTR));
        hit     = seen_q | acc;
        dec_bit = acc ? rise_i : pol_q;
        ph_inc  = (ph_q == PW'(OVS - 1)) ? '0 : ph_q + PW'(1);
    end

    // Phase counter with one correction step per cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= '0;
            adj_q <= ADJ_NONE;
        end else if (load_i) begin
            ph_q  <= PW'(1);
            adj_q <= ADJ_NONE;
        end else if (lock_q) begin
            if (ph_q == PW'(HALF) && adj_q == ADJ_SLIP) begin
                ph_q  <= ph_q;
                adj_q <= ADJ_NONE;
            end else if (ph_q == PW'(HALF) && adj_q == ADJ_SKIP) begin
                ph_q  <= ph_q + PW'(2);
                adj_q <= ADJ_NONE;
            end else begin
                ph_q <= ph_inc;
                if (acc) begin
                    if (off_i > 0) begin
                        adj_q <= ADJ_SLIP;
                    end else if (off_i < 0) begin
                        adj_q <= ADJ_SKIP;
                    end else begin
                        adj_q <= ADJ_NONE;
                    end
                end
            end
        end
    end

    // Per-cell edge capture: remember whether and which way the centre moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            pol_q  <= 1'b0;
        end else if (load_i) begin
            seen_q <= 1'b1;
            pol_q  <= 1'b0;
        end else if (strobe) begin
            seen_q <= 1'b0;
        end else if (acc) begin
            seen_q <= 1'b1;
            pol_q  <= rise_i;
        end
    end

    // Lock state, suppression of the locking cell, and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            mute_q <= 1'b0;
            bit_q  <= 1'b0;
            val_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            val_q <= 1'b0;
            err_q <= 1'b0;
            if (load_i) begin
                lock_q <= 1'b1;
                mute_q <= 1'b1;
            end else if (strobe) begin
                if (mute_q) begin
                    mute_q <= 1'b0;
                end else if (hit) begin
                    val_q <= 1'b1;
                    bit_q <= dec_bit;
                end else begin
                    err_q  <= 1'b1;
                    lock_q <= 1'b0;
                end
            end
        end
    end

    assign bit_o    = bit_q;
    assign valid_o  = val_q;
    assign err_o    = err_q;
    assign locked_o = lock_q;

endmodule

// File: rtl/manchester_rx.sv
// Manchester line receiver top.
// Chains the edge detector, the acquisition hunter (active only while
// unlocked) and the locked tracker/decoder.
// Assumes rx_in is synchronized and sampled OVS times per bit.
module manchester_rx #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic bit_out,
    output logic bit_valid,
    output logic locked,
    output logic decode_error
);

    logic edge_rise;
    logic edge_fall;
    logic acq_hit;
    logic hunt_en;

    // Hunting runs only while the tracker is not locked.
    assign hunt_en = ~locked;

    mrx_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_in),
        .rise_o (edge_rise),
        .fall_o (edge_fall)
    );

    mrx_acq #(.OVS(OVS)) u_acq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (hunt_en),
        .rise_i (edge_rise),
        .fall_i (edge_fall),
        .hit_o  (acq_hit)
    );

    mrx_track #(.OVS(OVS)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (acq_hit),
        .rise_i   (edge_rise),
        .fall_i   (edge_fall),
        .bit_o    (bit_out),
        .valid_o  (bit_valid),
        .err_o    (decode_error),
        .locked_o (locked)
    );

endmodule

// File: rtl/mrx_checker.sv
// Protocol checker for the Manchester line receiver, bound to the top.
// Assumes the top exposes the internal falling-edge flag as edge_fall.
module mrx_checker #(
    parameter int OVS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic locked,
    input logic bit_valid,
    input logic decode_error,
    input logic edge_fall
);

    logic [15:0] since_q;
    logic        had_q;

    // Cycles since the previous strobe within the current lock.
    always_ff @(posedge clk) begin
        if (!rst_n || !locked) begin
            since_q <= '0;
            had_q   <= 1'b0;
        end else if (bit_valid) begin
            since_q <= 16'd1;
            had_q   <= 1'b1;
        end else if (since_q != 16'hFFFF) begin
            since_q <= since_q + 16'd1;
        end
    end

    // R9: strobes only under lock
    p_valid_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> locked);

    // R9: never a strobe together with an error
    p_no_valid_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_valid && decode_error));

    // R8: an error leaves the block unlocked
    p_err_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        decode_error |-> !locked);

    // R8: the error is a single-cycle pulse
    p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        decode_error |=> !decode_error);

    // R8: lock is only lost through an error
    p_unlock_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> decode_error);

    // R2: lock follows a detected falling edge
    p_lock_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(edge_fall));

    // R4: strobe spacing stays within one sample of a bit period
    p_strobe_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && had_q) |-> (since_q >= 16'(OVS - 1) && since_q <= 16'(OVS + 1)));

endmodule

bind manchester_rx mrx_checker #(.OVS(OVS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .locked       (locked),
    .bit_valid    (bit_valid),
    .decode_error (decode_error),
    .edge_fall    (edge_fall)
);

// File: tb/manchester_rx_tb.sv
module manchester_rx_tb;

    localparam int OVS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_in = 1'b0;
    logic bit_out;
    logic bit_valid;
    logic locked;
    logic decode_error;

    always #4 clk = ~clk;

    manchester_rx #(.OVS(OVS)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_in        (rx_in),
        .bit_out      (bit_out),
        .bit_valid    (bit_valid),
        .locked       (locked),
        .decode_error (decode_error)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    int  rx_bits [0:511];
    int  rx_n;
    int  err_n;
    int  unl_valid = 0;
    int  fb [0:511];
    int  fn;
    real jit [0:1023];

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_valid) begin
                if (rx_n < 512) rx_bits[rx_n] = int'(bit_out);
                rx_n++;
                if (!locked) unl_valid++;
            end
            if (decode_error) err_n++;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Index of the bit whose falling centre completes the first 1,0,1,0 group.
    function automatic int lock_index();
        for (int i = 3; i < fn; i++) begin
            if (fb[i-3] == 1 && fb[i-2] == 0 && fb[i-1] == 1 && fb[i] == 0) return i;
        end
        return -1;
    endfunction

    task automatic build(int first, int npay);
        for (int i = 0; i < 8; i++) fb[i] = (i % 2 == 0) ? first : 1 - first;
        for (int i = 0; i < npay; i++) fb[8 + i] = int'($urandom_range(0, 1));
        fn = 8 + npay;
    endtask

    // Drive the frame half-cell by half-cell with rate offset and edge jitter.
    task automatic drive(real ofs, real start, real amp, int bad_bit, real bad_disp);
        real h;
        real last;
        int  m;
        int  idle;
        int  ncyc;
        int  lvl;
        h = (OVS / 2.0) * (1.0 + ofs);
        for (int k = 0; k <= 2 * fn; k++) begin
            jit[k] = 0.0;
            if (k >= 16 && k < 2 * fn && amp > 0.0)
                jit[k] = amp * ((real'($urandom_range(0, 2000)) / 1000.0) - 1.0);
        end
        if (bad_bit >= 0) jit[2 * bad_bit + 1] = bad_disp;
        idle = int'(rx_in);
        m = -1;
        last = start + 2.0 * fn * h + jit[2 * fn];
        ncyc = int'(last) + 3 * OVS;
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            while (m < 2 * fn && real'(n) >= start + (m + 1) * h + jit[m + 1]) m++;
            if (m < 0) lvl = idle;
            else if (m == 2 * fn) lvl = fb[fn - 1];
            else if (m % 2 == 0) lvl = 1 - fb[m / 2];
            else lvl = fb[m / 2];
            rx_in = lvl[0];
        end
    endtask

    task automatic run_frame(string tag, real ofs, real amp, int bad_bit, real bad_disp, bit clean);
        int  li;
        int  exp_n;
        int  ndiff;
        real start;
        check({tag, " R8 hunting before frame"}, int'(locked), 0);
        rx_n = 0;
        err_n = 0;
        start = 2.0 + real'($urandom_range(0, 1600)) / 100.0;
        drive(ofs, start, amp, bad_bit, bad_disp);
        li = lock_index();
        exp_n = fn - li - 1;
        ndiff = 0;
        for (int i = 0; i < exp_n && i < rx_n; i++)
            if (rx_bits[i] != fb[li + 1 + i]) ndiff++;
        if (clean) begin
            check({tag, " R2 bit count after lock"}, rx_n, exp_n);
            check({tag, " R4 mismatching bits"}, ndiff, 0);
            check({tag, " R8 end-of-frame errors"}, err_n, 1);
            check({tag, " R8 unlocked after frame"}, int'(locked), 0);
        end else begin
            check({tag, " R8 corrupted frame detected"},
                  int'((rx_n != exp_n) || (ndiff != 0) || (err_n != 1)), 1);
        end
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        repeat (5) @(negedge clk);
        check("R1 locked in reset", int'(locked), 0);
        check("R1 bit_valid in reset", int'(bit_valid), 0);
        check("R1 decode_error in reset", int'(decode_error), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 locked after reset", int'(locked), 0);
        repeat (20) @(negedge clk);

        build(1, 40);
        run_frame("nominal", 0.0, 0.0, -1, 0.0, 1'b1);
        build(0, 40);
        run_frame("R3 zero-first", 0.0, 0.0, -1, 0.0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            build(1, 30);
            run_frame("R3 random phase", 0.0, 0.0, -1, 0.0, 1'b1);
        end

        // Long runs of equal bits put boundary edges in every cell.
        build(1, 30);
        for (int i = 8; i < 20; i++) fb[i] = 1;
        for (int i = 20; i < 32; i++) fb[i] = 0;
        run_frame("R5 equal-bit runs", 0.0, 0.0, -1, 0.0, 1'b1);

        build(1, 80);
        run_frame("R6 rate +1pct", 0.01, 0.0, -1, 0.0, 1'b1);
        build(1, 80);
        run_frame("R6 rate -1pct", -0.01, 0.0, -1, 0.0, 1'b1);

        build(1, 80);
        run_frame("R7 jitter 2 samples", 0.0, 2.0, -1, 0.0, 1'b1);
        build(0, 80);
        run_frame("R7 jitter 2 samples", 0.0, 2.0, -1, 0.0, 1'b1);

        build(1, 40);
        fb[20] = 0; fb[21] = 1; fb[22] = 0;
        run_frame("R8 centre edge displaced 6", 0.0, 0.0, 21, 6.0, 1'b0);
        build(0, 40);
        fb[25] = 1; fb[26] = 0; fb[27] = 1;
        run_frame("R8 centre edge displaced -6", 0.0, 0.0, 26, -6.0, 1'b0);

        build(1, 40);
        run_frame("R8 relock", 0.0, 0.0, -1, 0.0, 1'b1);

        check("R9 strobes while unlocked", unl_valid, 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule